// File: doc/BRIEF.md
# Four-Pin GPIO Register Bank with Input Polarity Mask

This block is the register core behind a small serial-controlled general purpose I/O port. A command front end presents a register index together with a write strobe and write data, or a read request, and the block answers with a registered read byte. Four byte-wide registers sit behind the index. The first is a read-only view of the pin levels. The second holds the output drive values. The third is a per-bit polarity mask applied to the pin view. The fourth sets each pin's direction.

Each pin's level is passed through a two-flop synchronizer. The result is XORed with the polarity mask and returned in the low nibble of the pin-view register, whatever the direction of the pin. Direction bits drive the pad enables. A pin drives only while it is set as an output, and it then drives the value held in the output register. Reads of the output register return the stored flop contents, not the level seen on the pin. The asynchronous active-low reset takes effect at once and is released synchronously inside the block.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output register reads 0xFF, the polarity register reads 0x00 and the direction register reads 0xFF. Also after reset, pin_oe is 0000, pin_out is 0000 and rd_data is 0x00.
- R2: A write with reg_idx 0 changes no register, pin_out or pin_oe.
- R3: A read of index 0 returns 1 in bits 7:4. Bit i for i below 4 is the synchronized level of pin i XOR polarity bit i, and this holds for inputs and outputs alike.
- R4: The polarity register (index 2) stores all 8 written bits and reads them back. A 1 inverts the matching pin-view bit and a 0 passes it unchanged.
- R5: The output register (index 1) reads back the written byte, even when the pin levels differ from it.
- R6: For each pin i, pin_oe[i] is the inverse of direction bit i (index 3, 1 = input). pin_out[i] equals output bit i while the pin is an output and is 0 while it is an input, so output bits have no effect on input pins.
- R7: Bits 7:4 of registers 1 to 3 read back what was written and have no effect on pin_out or pin_oe.
- R8: rd_data is loaded on the clock edge where rd_en is high, using that cycle's reg_idx. It holds its value while rd_en is low.
- R9: A pin change applied before clock edge E1 is not seen by a read captured at edge E2, and is seen by a read captured at edge E3.
- R10: Driving rst_n low at any time clears pin_oe to 0000 at once and restores every register default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_idx | input | 2 | Register index: 0 pin view, 1 output, 2 polarity, 3 direction |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read request; loads rd_data on the next edge |
| rd_data | output | 8 | Registered read byte |
| pin_in | input | 4 | Sampled pad levels |
| pin_out | output | 4 | Pad drive values |
| pin_oe | output | 4 | Pad output enables, 1 = drive |

## Verification
The pin view is swept over all 16 pin levels against all 16 polarity masks, once with every pin set as an input and once with every pin set as an output. This separates a correct XOR from plain or inverted pass-through, and it shows that direction does not gate the view. All 256 bytes go through the output, polarity and direction registers. For the output register the pins are held at the complement of the written value, so a pin-sourced read is caught. The direction sweep checks pin enables and gated drive values for every byte, which isolates the upper-nibble storage from the pins. Directed cases cover writes to the read-only index, read-hold timing, the exact synchronizer latency edge and a reset asserted in mid-operation.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  typedef enum logic [1:0] {
    SEL_PINVIEW  = 2'd0,
    SEL_DRIVE    = 2'd1,
    SEL_POLARITY = 2'd2,
    SEL_DIR      = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_in;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_idx,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] drive_q,
  output logic [REG_W-1:0] pol_q,
  output logic [REG_W-1:0] dir_q
);

  logic             drive_en, pol_en, dir_en;
  logic [REG_W-1:0] drive_d,  pol_d,  dir_d;

  always_comb begin
    drive_en = wr_en && (reg_idx == SEL_DRIVE);
    pol_en   = wr_en && (reg_idx == SEL_POLARITY);
    dir_en   = wr_en && (reg_idx == SEL_DIR);
    drive_d  = drive_en ? wr_data : drive_q;
    pol_d    = pol_en   ? wr_data : pol_q;
    dir_d    = dir_en   ? wr_data : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '1;
      pol_q   <= '0;
      dir_q   <= '1;
    end else begin
      drive_q <= drive_d;
      pol_q   <= pol_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    reg_idx,
  input  logic                rd_en,
  input  logic [NUM_PINS-1:0] pins_sync,
  input  logic [REG_W-1:0]    drive_q,
  input  logic [REG_W-1:0]    pol_q,
  input  logic [REG_W-1:0]    dir_q,
  output logic [REG_W-1:0]    rd_data
);

  localparam int unsigned PAD_W = REG_W - NUM_PINS;

  logic [REG_W-1:0] pin_view;
  logic [REG_W-1:0] sel_data;
  logic [REG_W-1:0] rd_d;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb pin_view = {{PAD_W{1'b1}}, pins_sync ^ pol_q[NUM_PINS-1:0]};
    end else begin : g_nopad
      always_comb pin_view = pins_sync ^ pol_q[NUM_PINS-1:0];
    end
  endgenerate

  always_comb begin
    unique case (reg_idx)
      SEL_PINVIEW:  sel_data = pin_view;
      SEL_DRIVE:    sel_data = drive_q;
      SEL_POLARITY: sel_data = pol_q;
      default:      sel_data = dir_q;
    endcase
    rd_d = rd_en ? sel_data : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    reg_idx,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic                rd_en,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pins_sync;
  logic [REG_W-1:0]    drive_q, pol_q, dir_q;

  gpio_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) pin_sync_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_ctrl_regs #(.REG_W(REG_W)) ctrl_regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .drive_q (drive_q),
    .pol_q   (pol_q),
    .dir_q   (dir_q)
  );

  gpio_read_path #(.REG_W(REG_W), .NUM_PINS(NUM_PINS)) read_path_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_idx   (reg_idx),
    .rd_en     (rd_en),
    .pins_sync (pins_sync),
    .drive_q   (drive_q),
    .pol_q     (pol_q),
    .dir_q     (dir_q),
    .rd_data   (rd_data)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pad
      assign pin_oe[p]  = ~dir_q[p];
      assign pin_out[p] = drive_q[p] & ~dir_q[p];
    end
  endgenerate

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned NUM_PINS = 4
) (
  input logic                clk,
  input logic                ext_rst_n,
  input logic                rst_n,
  input logic [SEL_W-1:0]    reg_idx,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic                rd_en,
  input logic [REG_W-1:0]    rd_data,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  logic seen_low_q;
  always_ff @(posedge clk) seen_low_q <= !ext_rst_n;

  // R10
  always @(posedge clk) begin
    if (!ext_rst_n && seen_low_q) begin
      reset_oe_off_chk: assert (pin_oe == '0);
    end
  end

  // R2
  ro_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == SEL_PINVIEW) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R3
  pinview_upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == SEL_PINVIEW) |=> (rd_data[REG_W-1:NUM_PINS] == '1));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R6
  drive_only_when_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R6
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == SEL_DIR) |=> (pin_oe == ~$past(wr_data[NUM_PINS-1:0])));

endmodule

bind gpio_regbank gpio_regbank_chk #(.REG_W(REG_W), .NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .ext_rst_n (rst_n),
  .rst_n     (rst_sync_n),
  .reg_idx   (reg_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_regbank_tb_top.sv
`timescale 1ns/1ps
module gpio_regbank_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_idx;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic [3:0] pin_in;
  logic [3:0] pin_out;
  logic [3:0] pin_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  gpio_regbank dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [7:0] v);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] hold;
    rst_n = 1'b0; reg_idx = 2'd0; wr_en = 1'b0; wr_data = 8'h00;
    rd_en = 1'b0; pin_in = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", {4'h0, pin_oe}, 8'h00);
    check("R1 pin_out", {4'h0, pin_out}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    rd(2'd1, v); check("R1 output reg", v, 8'hFF);
    rd(2'd2, v); check("R1 polarity reg", v, 8'h00);
    rd(2'd3, v); check("R1 direction reg", v, 8'hFF);

    // R3 R4 pin view over all pins x masks, inputs then outputs
    for (int d = 0; d < 2; d++) begin
      wr(2'd3, (d == 0) ? 8'hFF : 8'hF0);
      for (int p = 0; p < 16; p++) begin
        wr(2'd2, {4'(p * 3), 4'(p)});
        for (int s = 0; s < 16; s++) begin
          set_pins(4'(s));
          rd(2'd0, v);
          check("R3 R4 pin view", v, {4'hF, 4'(s) ^ 4'(p)});
        end
      end
    end

    // R4 polarity readback
    for (int x = 0; x < 256; x++) begin
      wr(2'd2, 8'(x)); rd(2'd2, v);
      check("R4 polarity readback", v, 8'(x));
    end

    // R5 output readback vs complementary pins, R6 drive
    wr(2'd3, 8'h00);
    for (int x = 0; x < 256; x++) begin
      @(negedge clk); pin_in = ~4'(x);
      wr(2'd1, 8'(x)); rd(2'd1, v);
      check("R5 output readback", v, 8'(x));
      check("R6 pin_out all outputs", {4'h0, pin_out}, {4'h0, 4'(x)});
      check("R6 pin_oe all outputs", {4'h0, pin_oe}, 8'h0F);
    end

    // R6 R7 direction sweep with fixed drive
    wr(2'd1, 8'h3C);
    for (int x = 0; x < 256; x++) begin
      wr(2'd3, 8'(x)); rd(2'd3, v);
      check("R7 direction readback", v, 8'(x));
      check("R6 R7 pin_oe", {4'h0, pin_oe}, {4'h0, ~4'(x)});
      check("R6 R7 pin_out", {4'h0, pin_out}, {4'h0, 4'hC & ~4'(x)});
    end

    // R6 drive has no effect on input pins; R7 upper drive bits inert
    wr(2'd3, 8'hAF);
    for (int x = 0; x < 256; x += 17) begin
      wr(2'd1, 8'(x));
      check("R6 inputs ignore drive", {4'h0, pin_out}, 8'h00);
      check("R6 inputs oe off", {4'h0, pin_oe}, 8'h00);
    end
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hF5);
    check("R7 upper drive bits F", {4'h0, pin_out}, 8'h05);
    wr(2'd1, 8'h05);
    check("R7 upper drive bits 0", {4'h0, pin_out}, 8'h05);

    // R2 write to read-only index
    wr(2'd1, 8'h96); wr(2'd2, 8'h3A); wr(2'd3, 8'h5C);
    set_pins(4'h6);
    wr(2'd0, 8'h5A);
    check("R2 pin_out", {4'h0, pin_out}, {4'h0, 4'h6 & ~4'hC});
    check("R2 pin_oe", {4'h0, pin_oe}, 8'h03);
    rd(2'd1, v); check("R2 output reg", v, 8'h96);
    rd(2'd2, v); check("R2 polarity reg", v, 8'h3A);
    rd(2'd3, v); check("R2 direction reg", v, 8'h5C);
    rd(2'd0, v); check("R2 pin view", v, {4'hF, 4'h6 ^ 4'hA});

    // R8 hold while rd_en low
    hold = rd_data;
    wr(2'd2, 8'h11);
    set_pins(4'h9);
    repeat (3) @(negedge clk);
    check("R8 hold", rd_data, hold);
    @(negedge clk); reg_idx = 2'd2; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R8 load", rd_data, 8'h11);

    // R9 synchronizer latency
    wr(2'd2, 8'h00);
    set_pins(4'h0);
    @(negedge clk);
    pin_in = 4'hF; reg_idx = 2'd0; rd_en = 1'b1;
    @(negedge clk);
    check("R9 after E1", rd_data, 8'hF0);
    @(negedge clk);
    check("R9 after E2", rd_data, 8'hF0);
    @(negedge clk);
    check("R9 after E3", rd_data, 8'hFF);
    rd_en = 1'b0;

    // R10 reset in mid-operation
    wr(2'd3, 8'h00); wr(2'd1, 8'h0F); wr(2'd2, 8'hFF);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 oe immediate", {4'h0, pin_oe}, 8'h00);
    check("R10 out immediate", {4'h0, pin_out}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R10 output reg", v, 8'hFF);
    rd(2'd2, v); check("R10 polarity reg", v, 8'h00);
    rd(2'd3, v); check("R10 direction reg", v, 8'hFF);

    apply_reset();
    check("R1 rd_data after reset", rd_data, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule